// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Completion

This block gathers level-sensitive interrupt requests from a parameterised set of sources and sends them to a small set of target contexts. Each context has one interrupt output. Software sets a priority for each source, an enable mask for each context and a threshold for each context. For every context, the block picks the best eligible pending source.

A handler services an interrupt in two steps. It first reads its context's claim register, which returns a source ID and takes that source out of the pending set in the same cycle. After servicing the source, it writes the same ID back to that register. Source ID 0 is reserved and never exists. All registers sit behind a plain 32-bit bus with read and write strobes, an address and write data. Read data returns one cycle after the strobe, together with a valid flag.

Each source has its own gateway state machine with three states. GW_IDLE moves to GW_PENDING when the source's input level is high. GW_PENDING moves to GW_INFLIGHT when a claim read picks that source. GW_INFLIGHT moves back to GW_IDLE when a completion write carries that source's ID. From GW_IDLE, an input that is still high sets the source pending again.

Top module: `irq_router`

## Requirements
- R1: The priority of source ID n is at byte address 4*n, for n from 1 to NSRC. Only 3 bits are kept, and bits 31:3 read as zero. Address 0 (source 0) reads zero and ignores writes.
- R2: The enable mask of context c is at 0x2000 + 0x80*c. Source n uses bit (n mod 32) of word (n / 32). Bit 0 always reads zero.
- R3: The threshold of context c is at 0x200000 + 0x1000*c, and the claim/complete register is at that address + 4. The threshold keeps 3 bits.
- R4: irq_out[c] is high exactly when some source is pending, enabled for c, and has a priority strictly greater than c's threshold. A priority of 0 never interrupts.
- R5: A read of context c's claim register returns the ID of the eligible source with the highest priority. On a tie, the lowest ID wins. The read returns 0 when no source is eligible.
- R6: A claim read clears the chosen source's pending bit. That source is not delivered again until its ID is written to a claim/complete register. After that write, a level that is still high makes it pending again.
- R7: A completion write whose ID is not currently claimed changes nothing.
- R8: The pending bits are at 0x1000. Source n is bit (n mod 32) of word (n / 32), and bit 0 reads zero. Writes to this range are ignored.
- R9: Reads from unmapped or unaligned addresses return zero, and writes to them have no effect.
- R10: After reset, all priorities, enables, thresholds and pending bits are zero, and every irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NSRC | Level requests; bit k belongs to source ID k+1 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | High in the cycle bus_rdata is valid |
| irq_out | output | NCTX | One interrupt line per context |

## Verification
The assertions check on every cycle that at most one source is claimed at a time and that only a pending source can be claimed. They also check that a source becomes pending only from a high input level, that a claimed source stays in flight until its completion arrives, and that unmapped reads, the upper priority bits and enable bit 0 return zero. The bench scenarios cover the rest: arbitration order on tied priorities, the strict threshold comparison, how a claim by one context affects the other, that pending bits cannot be written, that stray completions are ignored, and that a source still held high becomes pending again after completion.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [1:0] {
        GW_IDLE     = 2'd0,
        GW_PENDING  = 2'd1,
        GW_INFLIGHT = 2'd2
    } gw_state_e;

    typedef enum logic [2:0] {
        AR_NONE   = 3'd0,
        AR_PRIO   = 3'd1,
        AR_PEND   = 3'd2,
        AR_ENABLE = 3'd3,
        AR_THRESH = 3'd4,
        AR_CLAIM  = 3'd5
    } areg_e;

    typedef struct packed {
        areg_e       kind;
        logic [15:0] idx;
        logic [15:0] ctx;
    } adec_t;

    localparam logic [31:0] PEND_BASE   = 32'h0000_1000;
    localparam logic [31:0] ENABLE_BASE = 32'h0000_2000;
    localparam logic [31:0] ENABLE_STEP = 32'h0000_0080;
    localparam logic [31:0] CTRL_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTRL_STEP   = 32'h0000_1000;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_router_pkg::*;
#(
    parameter int NSRC   = 7,
    parameter int NCTX   = 2,
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] addr,
    output adec_t             dec
);
    localparam int ENW = (NSRC + 1 + 31) / 32;

    logic [31:0] a;
    logic [31:0] off;
    logic [31:0] word;
    logic [31:0] sel;

    always_comb begin
        a    = 32'(addr);
        off  = '0;
        word = '0;
        sel  = '0;
        dec  = '{kind: AR_NONE, idx: '0, ctx: '0};
        if (a[1:0] == 2'b00) begin
            if (a < PEND_BASE) begin
                word = a >> 2;
                if (word >= 32'd1 && word <= 32'(NSRC)) begin
                    dec.kind = AR_PRIO;
                    dec.idx  = word[15:0];
                end
            end else if (a < PEND_BASE + 32'(4 * ENW)) begin
                word     = (a - PEND_BASE) >> 2;
                dec.kind = AR_PEND;
                dec.idx  = word[15:0];
            end else if (a >= ENABLE_BASE && a < ENABLE_BASE + ENABLE_STEP * 32'(NCTX)) begin
                off  = a - ENABLE_BASE;
                sel  = off >> 7;
                word = (off & 32'h7F) >> 2;
                if (word < 32'(ENW)) begin
                    dec.kind = AR_ENABLE;
                    dec.idx  = word[15:0];
                    dec.ctx  = sel[15:0];
                end
            end else if (a >= CTRL_BASE && a < CTRL_BASE + CTRL_STEP * 32'(NCTX)) begin
                off  = a - CTRL_BASE;
                sel  = off >> 12;
                word = off & 32'hFFF;
                dec.ctx = sel[15:0];
                if (word == 32'd0)      dec.kind = AR_THRESH;
                else if (word == 32'd4) dec.kind = AR_CLAIM;
                else                    dec.ctx  = '0;
            end
        end
    end

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic claim_hit,
    input  logic cmpl_hit,
    output logic pending,
    output logic inflight
);
    gw_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GW_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GW_IDLE:     if (level)     st_d = GW_PENDING;
            GW_PENDING:  if (claim_hit) st_d = GW_INFLIGHT;
            GW_INFLIGHT: if (cmpl_hit)  st_d = GW_IDLE;
            default:                    st_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending  = (st_q == GW_PENDING);
        inflight = (st_q == GW_INFLIGHT);
    end

    AST_PEND_FROM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(level)); // R6
    AST_CLAIM_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit |-> pending); // R5
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight && !cmpl_hit) |=> inflight); // R6

endmodule

// File: rtl/ctx_select.sv
module ctx_select #(
    parameter int NSRC   = 7,
    parameter int PRIO_W = 3,
    parameter int IDW    = 3
) (
    input  logic [NSRC:1]          cand,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]      thr,
    output logic [IDW-1:0]         best_id,
    output logic                   req
);
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] p;

    always_comb begin
        best_id = '0;
        best_p  = '0;
        p       = '0;
        for (int i = 1; i <= NSRC; i++) begin
            p = prio_flat[(i-1)*PRIO_W +: PRIO_W];
            if (cand[i] && (p > thr) && (p > best_p)) begin
                best_p  = p;
                best_id = IDW'(i);
            end
        end
        req = (best_id != '0);
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC   = 7,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [NCTX-1:0]   irq_out
);
    localparam int IDW = $clog2(NSRC + 1);
    localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1;

    adec_t             dec;
    logic [CW-1:0]     dctx;
    logic [PRIO_W-1:0] prio_q [1:NSRC];
    logic [NSRC:1]     en_q   [NCTX];
    logic [PRIO_W-1:0] thr_q  [NCTX];
    logic [IDW-1:0]    best   [NCTX];
    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [NSRC:1]     pend, infl, claim_vec, cmpl_vec;
    logic [31:0]       rd_mux;

    irq_addr_decode #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign dctx = dec.ctx[CW-1:0];

    for (genvar i = 1; i <= NSRC; i++) begin : g_src
        irq_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (irq_src[i-1]),
            .claim_hit (claim_vec[i]),
            .cmpl_hit  (cmpl_vec[i]),
            .pending   (pend[i]),
            .inflight  (infl[i])
        );
        assign prio_flat[(i-1)*PRIO_W +: PRIO_W] = prio_q[i];
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        ctx_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
            .cand      (pend & en_q[c]),
            .prio_flat (prio_flat),
            .thr       (thr_q[c]),
            .best_id   (best[c]),
            .req       (irq_out[c])
        );

        AST_IDLE_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && dec.kind == AR_CLAIM && dctx == CW'(c) && !irq_out[c])
            |=> (bus_rdata == 32'd0)); // R5
        AST_LIVE_CLAIM_ID: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && dec.kind == AR_CLAIM && dctx == CW'(c) && irq_out[c])
            |=> (bus_rdata != 32'd0)); // R5
    end

    // Claim pulses go to the winner of the addressed context; completion pulses
    // go to the written ID, and the gateway drops those that find it not in flight.
    always_comb begin
        claim_vec = '0;
        cmpl_vec  = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (bus_rd && dec.kind == AR_CLAIM && best[dctx] == IDW'(i))
                claim_vec[i] = 1'b1;
            if (bus_wr && dec.kind == AR_CLAIM && bus_wdata == 32'(i))
                cmpl_vec[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i <= NSRC; i++) prio_q[i] <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (bus_wr) begin
            case (dec.kind)
                AR_PRIO: begin
                    for (int i = 1; i <= NSRC; i++)
                        if (dec.idx == 16'(i)) prio_q[i] <= bus_wdata[PRIO_W-1:0];
                end
                AR_ENABLE: begin
                    for (int c = 0; c < NCTX; c++)
                        for (int i = 1; i <= NSRC; i++)
                            if (dctx == CW'(c) && dec.idx == 16'(i / 32))
                                en_q[c][i] <= bus_wdata[i % 32];
                end
                AR_THRESH: begin
                    for (int c = 0; c < NCTX; c++)
                        if (dctx == CW'(c)) thr_q[c] <= bus_wdata[PRIO_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            AR_PRIO: begin
                for (int i = 1; i <= NSRC; i++)
                    if (dec.idx == 16'(i)) rd_mux[PRIO_W-1:0] = prio_q[i];
            end
            AR_PEND: begin
                for (int i = 1; i <= NSRC; i++)
                    if (dec.idx == 16'(i / 32)) rd_mux[i % 32] = pend[i];
            end
            AR_ENABLE: begin
                for (int c = 0; c < NCTX; c++)
                    for (int i = 1; i <= NSRC; i++)
                        if (dctx == CW'(c) && dec.idx == 16'(i / 32))
                            rd_mux[i % 32] = en_q[c][i];
            end
            AR_THRESH: begin
                for (int c = 0; c < NCTX; c++)
                    if (dctx == CW'(c)) rd_mux[PRIO_W-1:0] = thr_q[c];
            end
            AR_CLAIM: rd_mux[IDW-1:0] = best[dctx];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= bus_rd ? rd_mux : 32'd0;
            bus_rvalid <= bus_rd;
        end
    end

    AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.kind == AR_NONE) |=> (bus_rdata == 32'd0)); // R9
    AST_PRIO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.kind == AR_PRIO) |=> (bus_rdata[31:PRIO_W] == '0)); // R1
    AST_ENABLE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.kind == AR_ENABLE && dec.idx == 16'd0) |=> !bus_rdata[0]); // R2

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;

    localparam int NSRC   = 7;
    localparam int NCTX   = 2;
    localparam int ADDR_W = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_src = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCTX-1:0]   irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    irq_router #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(ADDR_W)) i_irq_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_src    (irq_src),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_out    (irq_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 32'hDEAD_BEEF, "scoreboard underflow");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(bus_rdata, e.val, e.tag);
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a[ADDR_W-1:0];
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a[ADDR_W-1:0];
        e.val = exp;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_irq(input int c, input logic exp, input string tag);
        @(negedge clk);
        chk(32'(irq_out[c]), 32'(exp), tag);
    endtask

    localparam logic [31:0] EN0  = 32'h2000;
    localparam logic [31:0] EN1  = 32'h2080;
    localparam logic [31:0] PND  = 32'h1000;
    localparam logic [31:0] TH0  = 32'h20_0000;
    localparam logic [31:0] CL0  = 32'h20_0004;
    localparam logic [31:0] TH1  = 32'h20_1000;
    localparam logic [31:0] CL1  = 32'h20_1004;

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R10 reset state
        chk_irq(0, 1'b0, "R10 irq0 after reset");
        chk_irq(1, 1'b0, "R10 irq1 after reset");
        rd(32'h4, 32'h0, "R10 prio1 reset");
        rd(TH0, 32'h0, "R10 thresh0 reset");
        rd(EN1, 32'h0, "R10 enable1 reset");
        rd(PND, 32'h0, "R10 pending reset");
        rd(CL0, 32'h0, "R10 claim empty");

        // R1 priority width and source 0
        wr(32'h4, 32'hFFFF_FFFF);
        rd(32'h4, 32'h7, "R1 prio1 masked to 3 bits");
        wr(32'h0, 32'h5);
        rd(32'h0, 32'h0, "R1 source0 prio reads zero");

        // R2 enable layout
        wr(EN0, 32'hFFFF_FFFF);
        rd(EN0, 32'hFE, "R2 enable0 bits 1..7, bit0 zero");
        wr(EN1, 32'h10);
        rd(EN1, 32'h10, "R2 enable1 source4");

        // R9 unmapped
        wr(32'h2100, 32'hFFFF_FFFF);
        wr(32'h3000, 32'h1234);
        rd(32'h3000, 32'h0, "R9 unmapped read");
        rd(32'h2100, 32'h0, "R9 beyond last context");
        rd(EN0, 32'hFE, "R9 enable0 untouched");
        rd(EN1, 32'h10, "R9 enable1 untouched");

        // priorities: 1=7, 2=3, 3=3, 4=2, 5..7=0
        wr(32'h8, 32'h3);
        wr(32'hC, 32'h3);
        wr(32'h10, 32'h2);
        rd(32'hC, 32'h3, "R1 prio3 readback");

        // R4 priority 0 never interrupts at threshold 0
        irq_src = 7'b001_0000;          // source 5
        idle(2);
        chk_irq(0, 1'b0, "R4 prio0 blocked");
        rd(PND, 32'h20, "R8 pending source5");
        wr(PND, 32'h0);
        rd(PND, 32'h20, "R8 pending not writable");
        rd(CL0, 32'h0, "R5 claim none eligible");
        irq_src = '0;

        // R5 tie on priority 3, threshold 2
        wr(TH0, 32'h2);
        rd(TH0, 32'h2, "R3 thresh0 readback");
        irq_src = 7'b000_0110;          // sources 2 and 3
        idle(2);
        chk_irq(0, 1'b1, "R4 irq0 prio3 > thr2");
        chk_irq(1, 1'b0, "R4 irq1 not enabled");
        rd(CL0, 32'd2, "R5 tie lowest id");
        rd(PND, 32'h28, "R6 claim clears pending");
        rd(CL0, 32'd3, "R5 next claim");
        rd(PND, 32'h20, "R6 both claimed");
        chk_irq(0, 1'b0, "R6 claimed sources held off");

        // R7 stray completion
        wr(CL0, 32'd4);
        wr(CL0, 32'd0);
        idle(2);
        rd(PND, 32'h20, "R7 stray completion ignored");
        chk_irq(0, 1'b0, "R7 irq stays low");

        // R6 completion with level still high
        wr(CL0, 32'd2);
        idle(3);
        rd(PND, 32'h24, "R6 repended after completion");
        chk_irq(0, 1'b1, "R6 irq again");
        rd(CL0, 32'd2, "R6 claim again");
        irq_src = '0;
        wr(CL0, 32'd2);
        wr(CL0, 32'd3);
        idle(3);
        rd(PND, 32'h20, "R6 level low stays idle");
        chk_irq(0, 1'b0, "R6 irq0 low");

        // R4 strict threshold, R5 priority order across contexts
        wr(TH0, 32'h7);
        irq_src = 7'b000_1001;          // sources 1 and 4
        idle(2);
        chk_irq(0, 1'b0, "R4 prio7 equal thr7 blocked");
        rd(CL0, 32'h0, "R4 claim blocked by threshold");
        wr(TH0, 32'h6);
        chk_irq(0, 1'b1, "R4 prio7 > thr6");
        rd(TH0, 32'h6, "R3 thresh0 6");
        wr(EN1, 32'h12);
        rd(EN1, 32'h12, "R2 enable1 sources 1,4");
        chk_irq(1, 1'b1, "R4 irq1 raised");
        rd(CL1, 32'd1, "R5 highest priority first");
        rd(CL1, 32'd4, "R5 lower priority next");
        chk_irq(1, 1'b0, "R6 irq1 after claims");
        chk_irq(0, 1'b0, "R6 claim by ctx1 clears ctx0");
        irq_src = '0;
        wr(CL1, 32'd1);
        wr(CL1, 32'd4);
        idle(3);
        rd(PND, 32'h20, "R6 completed through ctx1");
        rd(TH1, 32'h0, "R3 thresh1 untouched");

        // R9 unaligned and hole in control page
        rd(32'h20_0008, 32'h0, "R9 control hole");
        rd(32'h6, 32'h0, "R9 unaligned");

        idle(3);
        if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'd0, "scoreboard leftover");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule